// File: doc/BRIEF.md
# Interrupt CPU Interface Arbiter

This block sits between an interrupt distributor and one processor. The distributor offers a single best candidate each cycle: a valid flag, an interrupt ID, its priority and, for software interrupts, the ID of the CPU that raised it. The block decides whether that candidate may interrupt the processor. It raises a registered request line when three conditions hold: signalling is enabled, the candidate beats the priority mask, and the candidate may preempt whatever is already being serviced.

The processor uses a small register port. It reads an acknowledge register to claim the candidate. That read pushes the candidate's ID and priority onto a four-entry stack of active interrupts. The processor later writes the same ID to an end-of-interrupt register, which pops the stack. The top of the stack is the running priority. Preemption compares only the group-priority bits chosen by a 3-bit binary point, so priorities in the same group never nest.

Priorities are numeric and a lower value is more urgent. Register offsets are byte addresses on a 5-bit address bus. Reads return data combinationally in the cycle `rdEn` is high. Writes and the side effects of an acknowledge read take hold at the clock edge that ends that cycle.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset, the control, mask and binary point registers read 0, the running priority reads 0xFF and `irqOut` is low.
- R2: Control register (offset 0x00) bit 0 enables signalling. While it is 0, `irqOut` stays low and an acknowledge read returns 1023.
- R3: A candidate is signalled only if its priority is numerically lower than the priority mask register (offset 0x04, bits 7:0).
- R4: The binary point register (offset 0x08, bits 2:0) selects the group mask 0xFF shifted left by (value+1), giving 0xFE for 0 through 0x00 for 7. While an interrupt is active, a candidate is signalled only if (candidate priority AND mask) is strictly lower than (running priority AND mask). While none is active, this test is waived.
- R5: A successful acknowledge read (offset 0x0C) returns the candidate ID in bits 9:0 and the source CPU in bits 11:10, with the upper bits 0. It pushes the candidate onto the active stack, and `irqOut` is low in the cycle after the read.
- R6: An acknowledge read while no candidate is signalled returns 1023 and leaves the running priority unchanged.
- R7: The active stack holds 4 entries. While it is full, nothing is signalled and an acknowledge read returns 1023.
- R8: An end-of-interrupt write (offset 0x10, ID in bits 9:0) pops the stack only if the ID matches the most recently acknowledged active interrupt. A mismatched ID is ignored.
- R9: The running priority register (offset 0x14) returns the priority at the top of the stack, or 0xFF when the stack is empty. The highest pending register (offset 0x18) returns the candidate ID, or 1023 when no candidate is valid.
- R10: Writes to offsets 0x00, 0x04 and 0x08 are read back from the same offsets, masked to 1, 8 and 3 bits respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| candValid | input | 1 | Distributor offers a candidate |
| candId | input | 10 | Candidate interrupt ID |
| candPrio | input | 8 | Candidate priority, lower is more urgent |
| candSrc | input | 2 | Source CPU of a software interrupt |
| addr | input | 5 | Register byte offset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdEn | input | 1 | Register read strobe; an acknowledge read has side effects |
| rdData | output | 32 | Register read data, valid while rdEn is high |
| irqOut | output | 1 | Registered interrupt request to the processor |

## Verification
The bench sweeps every candidate priority against all eight binary points with one interrupt active. A group mask that is off by one bit, or a compare that is not strict, makes `irqOut` rise for same-group candidates. A second sweep runs every priority against several mask values. A design that lets a priority equal to the mask through, or that inverts the urgency order, is caught there. Nesting is driven to the full stack and unwound with both mismatched and matching end-of-interrupt writes. A stack that overflows, or that pops on a wrong ID, reports the wrong running priority. Acknowledge reads with signalling disabled and with a full stack must return 1023 and must not move the running priority.

// File: rtl/irq_cpu_if_pkg.sv
package irq_cpu_if_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_MASK = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_BPT  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_ACK  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_EOI  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_RUN  = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_PEND = 5'h18;

  typedef struct packed {
    logic wrCtrl;
    logic wrMask;
    logic wrBpt;
    logic ackOk;   // a candidate may be claimed now
    logic push;    // acknowledge read claims it
    logic pop;     // end-of-interrupt retires top entry
  } ctlStrobes_t;
endpackage

// File: rtl/irq_cpu_if_datapath.sv
module irq_cpu_if_datapath
  import irq_cpu_if_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 2,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       stb,
  input  logic              candValid,
  input  logic [ID_W-1:0]   candId,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic [SRC_W-1:0]  candSrc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              ctrlEn,
  output logic              signalOk,
  output logic              notEmpty,
  output logic [ID_W-1:0]   topId
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);
  localparam logic [ID_W-1:0] SPURIOUS = '1;
  localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

  logic [PRIO_W-1:0] prioMask;
  logic [2:0]        binPt;
  logic [PTR_W-1:0]  depth;
  logic [PRIO_W-1:0] stkPrio [DEPTH];
  logic [ID_W-1:0]   stkId   [DEPTH];
  logic [IDX_W-1:0]  topIdx;
  logic [PRIO_W-1:0] runPrio;
  logic [PRIO_W-1:0] groupMask;

  assign topIdx    = IDX_W'(depth - 1'b1);
  assign notEmpty  = (depth != '0);
  assign runPrio   = notEmpty ? stkPrio[topIdx] : IDLE_PRIO;
  assign topId     = stkId[topIdx];
  assign groupMask = PRIO_W'(IDLE_PRIO << ({1'b0, binPt} + 4'd1));

  always_comb begin
    signalOk = candValid && (candPrio < prioMask) && (depth != FULL);
    if (notEmpty && !((candPrio & groupMask) < (runPrio & groupMask)))
      signalOk = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlEn   <= 1'b0;
      prioMask <= '0;
      binPt    <= '0;
      depth    <= '0;
    end else begin
      if (stb.wrCtrl) ctrlEn   <= wrData[0];
      if (stb.wrMask) prioMask <= wrData[PRIO_W-1:0];
      if (stb.wrBpt)  binPt    <= wrData[2:0];
      if (stb.push)     depth <= depth + 1'b1;
      else if (stb.pop) depth <= depth - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_stack
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stkPrio[i] <= '1;
        stkId[i]   <= '0;
      end else if (stb.push && depth == PTR_W'(i)) begin
        stkPrio[i] <= candPrio;
        stkId[i]   <= candId;
      end
    end
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      OFS_CTRL: rdData = 32'(ctrlEn);
      OFS_MASK: rdData = 32'(prioMask);
      OFS_BPT:  rdData = 32'(binPt);
      OFS_ACK:  rdData = stb.ackOk ? 32'({candSrc, candId}) : 32'(SPURIOUS);
      OFS_RUN:  rdData = 32'(runPrio);
      OFS_PEND: rdData = candValid ? 32'(candId) : 32'(SPURIOUS);
      default:  rdData = '0;
    endcase
  end

  // R7: a claim never lands on a full stack
  a_r7_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    stb.push |-> depth != FULL);
  // R8: retiring needs an active entry
  a_r8_pop_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
    stb.pop |-> depth != '0);
  // R6: without claim or retire the stack depth holds
  a_r6_depth_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.push && !stb.pop) |=> $stable(depth));
endmodule

// File: rtl/irq_cpu_if_ctrl.sv
module irq_cpu_if_ctrl
  import irq_cpu_if_pkg::*;
#(
  parameter int ID_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [31:0]       wrData,
  input  logic              ctrlEn,
  input  logic              signalOk,
  input  logic              notEmpty,
  input  logic [ID_W-1:0]   topId,
  output ctlStrobes_t       stb,
  output logic              irqOut
);
  logic irqQ;

  always_comb begin
    stb        = '0;
    stb.wrCtrl = wrEn && addr == OFS_CTRL;
    stb.wrMask = wrEn && addr == OFS_MASK;
    stb.wrBpt  = wrEn && addr == OFS_BPT;
    stb.ackOk  = ctrlEn && signalOk;
    stb.push   = rdEn && addr == OFS_ACK && stb.ackOk;
    stb.pop    = wrEn && addr == OFS_EOI && notEmpty && wrData[ID_W-1:0] == topId;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqQ <= 1'b0;
    else        irqQ <= ctrlEn && signalOk && !stb.push;
  end

  assign irqOut = irqQ;

  // R2: a request only follows an enabled cycle
  a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irqQ |-> $past(ctrlEn));
  // R5: request is down right after a claim
  a_r5_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    stb.push |=> !irqQ);
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import irq_cpu_if_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 2,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              candValid,
  input  logic [ID_W-1:0]   candId,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic [SRC_W-1:0]  candSrc,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  output logic [31:0]       rdData,
  output logic              irqOut
);
  ctlStrobes_t     stb;
  logic            ctrlEn, signalOk, notEmpty;
  logic [ID_W-1:0] topId;

  irq_cpu_if_ctrl #(.ID_W(ID_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .ctrlEn(ctrlEn), .signalOk(signalOk),
    .notEmpty(notEmpty), .topId(topId), .stb(stb), .irqOut(irqOut)
  );

  irq_cpu_if_datapath #(.ID_W(ID_W), .PRIO_W(PRIO_W), .SRC_W(SRC_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .candValid(candValid),
    .candId(candId), .candPrio(candPrio), .candSrc(candSrc), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ctrlEn(ctrlEn), .signalOk(signalOk),
    .notEmpty(notEmpty), .topId(topId)
  );
endmodule

// File: tb/irq_cpu_if_test.sv
module irq_cpu_if_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 0, rst_n = 0;
  logic        candValid = 0;
  logic [9:0]  candId = 0;
  logic [7:0]  candPrio = 8'hFF;
  logic [1:0]  candSrc = 0;
  logic [4:0]  addr = 0;
  logic        wrEn = 0, rdEn = 0;
  logic [31:0] wrData = 0, rdData;
  logic        irqOut;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  irq_cpu_if uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic doRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rdEn = 1; #1 d = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic offer(input logic v, input logic [9:0] id, input logic [7:0] p, input logic [1:0] s);
    @(negedge clk); candValid = v; candId = id; candPrio = p; candSrc = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  gm;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    doRead(5'h00, d); check("R1 ctrl", d, 0);
    doRead(5'h04, d); check("R1 mask", d, 0);
    doRead(5'h08, d); check("R1 bpt", d, 0);
    doRead(5'h14, d); check("R1 running", d, 32'hFF);
    check("R1 irq", {31'b0, irqOut}, 0);

    // R10 read-back masking
    doWrite(5'h00, 32'hFFFF_FFFF); doRead(5'h00, d); check("R10 ctrl", d, 1);
    doWrite(5'h04, 32'h1234_56A5); doRead(5'h04, d); check("R10 mask", d, 32'hA5);
    doWrite(5'h08, 32'hFFFF_FFFD); doRead(5'h08, d); check("R10 bpt", d, 5);
    doWrite(5'h08, 0);

    // R2 disabled: no request, spurious ack
    doWrite(5'h04, 32'hFF);
    doWrite(5'h00, 0);
    offer(1, 10'd33, 8'h10, 2'd1);
    check("R2 irq disabled", {31'b0, irqOut}, 0);
    doRead(5'h0C, d); check("R2 ack disabled", d, 1023);
    doRead(5'h14, d); check("R6 running after spurious", d, 32'hFF);
    doWrite(5'h00, 1);

    // R9 highest pending
    doRead(5'h18, d); check("R9 pending", d, 33);
    offer(0, 10'd33, 8'h10, 2'd1);
    doRead(5'h18, d); check("R9 pending none", d, 1023);
    check("R6 irq no cand", {31'b0, irqOut}, 0);
    doRead(5'h0C, d); check("R6 ack none", d, 1023);
    doRead(5'h14, d); check("R6 running unchanged", d, 32'hFF);

    // R3 mask sweep, nothing active
    foreach (d[k]) begin end
    for (int mi = 0; mi < 4; mi++) begin
      logic [7:0] m;
      m = (mi == 0) ? 8'h00 : (mi == 1) ? 8'h10 : (mi == 2) ? 8'h80 : 8'hFF;
      doWrite(5'h04, 32'(m));
      for (int p = 0; p < 256; p++) begin
        offer(1, 10'd7, 8'(p), 2'd0);
        check("R3 mask sweep", {31'b0, irqOut}, {31'b0, (8'(p) < m)});
      end
    end

    // R4 binary point sweep with one active at 0x85
    doWrite(5'h04, 32'hFF);
    for (int b = 0; b < 8; b++) begin
      doWrite(5'h08, 32'(b));
      gm = 8'(8'hFF << (b + 1));
      offer(1, 10'd5, 8'h85, 2'd2);
      check("R4 idle signals", {31'b0, irqOut}, 1);
      doRead(5'h0C, d); check("R5 ack data", d, {20'b0, 2'd2, 10'd5});
      check("R5 irq drop", {31'b0, irqOut}, 0);
      doRead(5'h14, d); check("R9 running", d, 32'h85);
      for (int p = 0; p < 256; p++) begin
        offer(1, 10'd7, 8'(p), 2'd0);
        check("R4 preempt sweep", {31'b0, irqOut},
              {31'b0, (8'(p) < 8'hFF) && ((8'(p) & gm) < (8'h85 & gm))});
      end
      offer(0, 0, 8'hFF, 0);
      doWrite(5'h10, 32'd5);
      doRead(5'h14, d); check("R8 pop to idle", d, 32'hFF);
    end

    // R7/R8 nesting to full depth
    doWrite(5'h08, 0);
    for (int n = 0; n < 4; n++) begin
      logic [7:0] p;
      p = 8'(8'hC0 >> n);
      offer(1, 10'(100 + n), p, 2'd3);
      check("R7 nest irq", {31'b0, irqOut}, 1);
      doRead(5'h0C, d); check("R5 nest ack", d, {20'b0, 2'd3, 10'(100 + n)});
      doRead(5'h14, d); check("R9 nest running", d, 32'(p));
    end
    offer(1, 10'd200, 8'h00, 2'd0);
    check("R7 full no irq", {31'b0, irqOut}, 0);
    doRead(5'h0C, d); check("R7 full spurious", d, 1023);
    doRead(5'h14, d); check("R7 running kept", d, 32'h18);
    offer(0, 0, 8'hFF, 0);
    doWrite(5'h10, 32'd100);
    doRead(5'h14, d); check("R8 mismatch ignored", d, 32'h18);
    for (int n = 3; n >= 0; n--) begin
      doWrite(5'h10, 32'(100 + n));
      doRead(5'h14, d);
      check("R8 unwind", d, (n == 0) ? 32'hFF : 32'(8'hC0 >> (n - 1)));
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule